// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the target side of a three-wire serial memory link (select, serial clock, serial data in, serial data out). It brings the three link pins into the system clock domain, finds the start bit and collects the opcode, the word address and any write data. Reads are served straight from an internal byte array, and a read keeps streaming consecutive words for as long as select stays high. An organization input selects a wide layout (16-bit words, 8-bit word address) or a narrow layout (8-bit words, 9-bit word address). Write, erase, write-all and erase-all are not carried out here. When select falls after a complete frame, the block hands them to a separate program-cycle block as a one-cycle command strobe, and it does so only while programming is unlocked. That program-cycle block updates the array through the byte write port.

The controller has four states. `ST_IDLE` waits for a start bit. `ST_SHIFT` collects opcode, address and data bits. `ST_STREAM` drives read data. `ST_HOLD` keeps a complete non-read frame and ignores further clocks. The transitions are:
- `ST_IDLE -> ST_SHIFT` on a serial clock rise with data in high.
- `ST_SHIFT -> ST_STREAM` after the last address bit of a read.
- `ST_SHIFT -> ST_HOLD` after the last address bit of a command that carries no data, or after the last data bit of a command that does.
- Any state returns to `ST_IDLE` whenever the synchronized select is low.

Top module: `mw_eeprom_front`

## Requirements
- R1: While select is high, serial clock rises with data in low are ignored. The first rise with data in high is the start bit. The output enable stays low until a read header is complete.
- R2: After the start bit the frame carries a 2-bit opcode, then the address MSB first, then any data MSB first. The address is 8 bits when `org_wide`=1 and 9 bits when it is 0. Counted from the start bit, the frame is 11 (wide) or 12 (narrow) clocks for commands without data, and 27 or 20 clocks for read and write. If select drops before the last required bit, nothing is executed.
- R3: Opcode 10 is read, 01 is write and 11 is erase. With opcode 00, the two top address bits choose the command: 00 locks programming, 11 unlocks it, 10 is erase-all and 01 is write-all. `cmd_kind` is 0 for write, 1 for erase, 2 for write-all and 3 for erase-all.
- R4: Programming is locked after reset. A write, erase, write-all or erase-all raises `cmd_stb` only while programming is unlocked.
- R5: On a read, `mw_do_oe` rises on the clock that carries the last address bit and `mw_do` shows a 0 dummy bit. Each following clock rise shows the next data bit, MSB first.
- R6: While select stays high, the next word follows directly after the last bit of a word, with no dummy bit. The address wraps from the top word (511 narrow, 255 wide) to 0.
- R7: When select is low, `mw_do_oe` is 0 and the frame logic returns to idle. After reset, `mw_do_oe` and `cmd_stb` are 0.
- R8: Once a non-read frame is complete, further clocks and data bits do not change the command it carries.
- R9: A read returns data whether programming is locked or unlocked.
- R10: The array holds bytes written through `mem_we`/`mem_wa`/`mem_wd`. A narrow word A is byte A. A wide word A is byte 2A in bits 15:8 and byte 2A+1 in bits 7:0.
- R11: A command is issued as a `cmd_stb` pulse lasting one system clock, after select falls on a complete frame. `cmd_addr` is the word address for write and erase and 0 for write-all and erase-all. `cmd_data` is the data word for write and write-all (narrow data in bits 7:0) and 0 for erase and erase-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs | input | 1 | Link select, asynchronous |
| mw_clk | input | 1 | Link serial clock, asynchronous |
| mw_di | input | 1 | Link serial data in |
| org_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| mw_do | output | 1 | Serial data out value |
| mw_do_oe | output | 1 | Output enable for the data out pad driver |
| mem_we | input | 1 | Array byte write strobe |
| mem_wa | input | 9 | Array byte address for writes |
| mem_wd | input | 8 | Array write byte |
| cmd_stb | output | 1 | One-cycle command strobe to the program-cycle block |
| cmd_kind | output | 2 | Command kind: 0 write, 1 erase, 2 write-all, 3 erase-all |
| cmd_addr | output | 9 | Word address of the command |
| cmd_data | output | 16 | Data word of the command |

## Verification
The assertions assume several things about the inputs. Every link pin is stable for longer than the synchronizer depth. Data in is already settled when the serial clock rises. `org_wide` does not change while select is high. The array port is not written during a read. The stimulus meets these by holding each serial clock phase for eight system clocks and changing data in only in the low phase. It changes the organization and loads the array only while select is low, and it keeps select low for at least twelve system clocks between frames.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    // opcode field values shifted in after the start bit
    localparam logic [1:0] OP_EXT = 2'b00;
    localparam logic [1:0] OP_WR  = 2'b01;
    localparam logic [1:0] OP_RD  = 2'b10;
    localparam logic [1:0] OP_ER  = 2'b11;
    // sub-codes carried in the two top address bits of an OP_EXT frame
    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLEAR  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE, ST_SHIFT, ST_STREAM, ST_HOLD
    } fe_state_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_LOCK, ACT_UNLOCK, ACT_WRITE, ACT_ERASE, ACT_FILL, ACT_CLEAR
    } fe_act_e;

    typedef enum logic [1:0] {
        PK_WRITE = 2'd0, PK_ERASE = 2'd1, PK_FILL = 2'd2, PK_CLEAR = 2'd3
    } pgm_kind_e;
endpackage

// File: rtl/mw_pin_sync.sv
`timescale 1ns/1ps
module mw_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin_i[g]};
            end
            assign lvl_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mw_byte_store.sv
`timescale 1ns/1ps
module mw_byte_store #(
    parameter int BYTE_W = 8,
    parameter int BA_W   = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BA_W-1:0]   wa,
    input  logic [BYTE_W-1:0] wd,
    input  logic [BA_W-1:0]   ra,
    output logic [BYTE_W-1:0] rd_hi,
    output logic [BYTE_W-1:0] rd_lo
);
    localparam int DEPTH = 1 << BA_W;
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // rd_hi is the addressed byte; rd_lo is its odd partner (low half of a wide word)
    assign rd_hi = mem[ra];
    assign rd_lo = mem[{ra[BA_W-1:1], 1'b1}];
endmodule

// File: rtl/mw_eeprom_front.sv
`timescale 1ns/1ps
module mw_eeprom_front
    import mw_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int BA_W        = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mw_cs,
    input  logic                mw_clk,
    input  logic                mw_di,
    input  logic                org_wide,
    output logic                mw_do,
    output logic                mw_do_oe,
    input  logic                mem_we,
    input  logic [BA_W-1:0]     mem_wa,
    input  logic [BYTE_W-1:0]   mem_wd,
    output logic                cmd_stb,
    output logic [1:0]          cmd_kind,
    output logic [BA_W-1:0]     cmd_addr,
    output logic [2*BYTE_W-1:0] cmd_data
);
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int WA_W       = BA_W - 1;
    localparam int HDR_NARROW = 2 + BA_W;
    localparam int HDR_WIDE   = 2 + WA_W;
    localparam int MAX_BITS   = HDR_WIDE + WORD_W;
    localparam int CNT_W      = $clog2(MAX_BITS + 1);
    localparam int OUT_W      = $clog2(WORD_W);

    // ---------------- pin synchronization and edges ----------------
    logic [2:0] pin_lvl;
    logic cs_s, sck_s, di_s, cs_d, sck_d, sck_rise, cs_fall;

    mw_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({mw_di, mw_clk, mw_cs}),
        .lvl_o (pin_lvl)
    );
    assign cs_s  = pin_lvl[0];
    assign sck_s = pin_lvl[1];
    assign di_s  = pin_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end
    assign sck_rise = sck_s & ~sck_d;
    assign cs_fall  = cs_d & ~cs_s;

    // ---------------- frame state ----------------
    fe_state_e           st, st_nxt;
    fe_act_e             act_q, hdr_act;
    logic [CNT_W-1:0]    bitcnt, cnt_inc, hdr_len, dw_len;
    logic [1:0]          op_q, sub_code;
    logic [BA_W-1:0]     addr_q, addr_nxt, addr_inc, rd_addr;
    logic [WORD_W-1:0]   data_q, data_nxt, rd_sh, word_now;
    logic [OUT_W-1:0]    out_cnt;
    logic [BYTE_W-1:0]   rd_hi, rd_lo;
    logic                wen_q, in_frame, hdr_last, data_last, need_data, out_last;

    mw_byte_store #(.BYTE_W(BYTE_W), .BA_W(BA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wa    (mem_wa),
        .wd    (mem_wd),
        .ra    (rd_addr),
        .rd_hi (rd_hi),
        .rd_lo (rd_lo)
    );

    assign hdr_len   = org_wide ? CNT_W'(HDR_WIDE) : CNT_W'(HDR_NARROW);
    assign dw_len    = org_wide ? CNT_W'(WORD_W)   : CNT_W'(BYTE_W);
    assign cnt_inc   = bitcnt + 1'b1;
    assign addr_nxt  = {addr_q[BA_W-2:0], di_s};
    assign data_nxt  = {data_q[WORD_W-2:0], di_s};
    assign sub_code  = org_wide ? addr_nxt[WA_W-1 -: 2] : addr_nxt[BA_W-1 -: 2];
    assign in_frame  = (st == ST_SHIFT) && sck_rise;
    assign hdr_last  = in_frame && (cnt_inc == hdr_len);
    assign data_last = in_frame && (cnt_inc == hdr_len + dw_len);
    assign need_data = (op_q == OP_WR) || ((op_q == OP_EXT) && (sub_code == SUB_FILL));

    // read path: words are left-aligned so the MSB always sits at the top bit
    assign rd_addr  = org_wide ? {addr_q[WA_W-1:0], 1'b0} : addr_q;
    assign word_now = org_wide ? {rd_hi, rd_lo} : {rd_hi, {BYTE_W{1'b0}}};
    assign addr_inc = org_wide ? {1'b0, WA_W'(addr_q[WA_W-1:0] + 1'b1)} : addr_q + 1'b1;
    assign out_last = out_cnt == (org_wide ? OUT_W'(WORD_W - 1) : OUT_W'(BYTE_W - 1));

    always_comb begin
        hdr_act = ACT_NONE;
        case (op_q)
            OP_ER:  hdr_act = ACT_ERASE;
            OP_EXT: begin
                case (sub_code)
                    SUB_LOCK:   hdr_act = ACT_LOCK;
                    SUB_UNLOCK: hdr_act = ACT_UNLOCK;
                    SUB_CLEAR:  hdr_act = ACT_CLEAR;
                    default:    hdr_act = ACT_NONE;
                endcase
            end
            default: hdr_act = ACT_NONE;
        endcase
    end

    // ---------------- state register ----------------
    always_comb begin
        st_nxt = st;
        if (!cs_s) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   if (sck_rise && di_s) st_nxt = ST_SHIFT;
                ST_SHIFT: begin
                    if (hdr_last)
                        st_nxt = (op_q == OP_RD) ? ST_STREAM : (need_data ? ST_SHIFT : ST_HOLD);
                    else if (data_last)
                        st_nxt = ST_HOLD;
                end
                ST_STREAM: st_nxt = ST_STREAM;
                ST_HOLD:   st_nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            act_q    <= ACT_NONE;
            wen_q    <= 1'b0;
            rd_sh    <= '0;
            out_cnt  <= '0;
            mw_do    <= 1'b0;
            mw_do_oe <= 1'b0;
            cmd_stb  <= 1'b0;
            cmd_kind <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (!cs_s) begin
                mw_do_oe <= 1'b0;
                mw_do    <= 1'b0;
                if (cs_fall && st == ST_HOLD) begin
                    case (act_q)
                        ACT_LOCK:   wen_q <= 1'b0;
                        ACT_UNLOCK: wen_q <= 1'b1;
                        ACT_WRITE, ACT_ERASE, ACT_FILL, ACT_CLEAR: begin
                            if (wen_q) begin
                                cmd_stb  <= 1'b1;
                                cmd_kind <= (act_q == ACT_WRITE) ? PK_WRITE :
                                            (act_q == ACT_ERASE) ? PK_ERASE :
                                            (act_q == ACT_FILL)  ? PK_FILL  : PK_CLEAR;
                                cmd_addr <= (act_q == ACT_WRITE || act_q == ACT_ERASE) ? addr_q : '0;
                                cmd_data <= (act_q == ACT_WRITE || act_q == ACT_FILL) ? data_q : '0;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (st == ST_IDLE && sck_rise && di_s) begin
                bitcnt <= '0;
                op_q   <= '0;
                addr_q <= '0;
                data_q <= '0;
                act_q  <= ACT_NONE;
            end else if (in_frame) begin
                bitcnt <= cnt_inc;
                if (bitcnt < CNT_W'(2))   op_q   <= {op_q[0], di_s};
                else if (bitcnt < hdr_len) addr_q <= addr_nxt;
                else                       data_q <= data_nxt;
                if (hdr_last) begin
                    if (op_q == OP_RD) begin
                        mw_do_oe <= 1'b1;
                        mw_do    <= 1'b0;
                        out_cnt  <= '0;
                    end else if (!need_data) begin
                        act_q <= hdr_act;
                    end
                end
                if (data_last) act_q <= (op_q == OP_WR) ? ACT_WRITE : ACT_FILL;
            end else if (st == ST_STREAM && sck_rise) begin
                if (out_cnt == '0) begin
                    mw_do <= word_now[WORD_W-1];
                    rd_sh <= {word_now[WORD_W-2:0], 1'b0};
                end else begin
                    mw_do <= rd_sh[WORD_W-1];
                    rd_sh <= {rd_sh[WORD_W-2:0], 1'b0};
                end
                if (out_last) begin
                    out_cnt <= '0;
                    addr_q  <= addr_inc;
                end else begin
                    out_cnt <= out_cnt + 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    a_r7_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !mw_do_oe);
    a_r5_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_do_oe) |-> !mw_do);
    a_r11_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    a_r11_strobe_after_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(cs_fall));
    a_r4_strobe_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> wen_q);
    a_r8_hold_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !mw_do_oe);
endmodule

// File: tb/mw_eeprom_front_test.sv
`timescale 1ns/1ps
module mw_eeprom_front_test;
    localparam int HALF = 8;
    localparam int FULL = 99;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mw_cs = 1'b0, mw_clk = 1'b0, mw_di = 1'b0, org_wide = 1'b0;
    logic mw_do, mw_do_oe, cmd_stb;
    logic mem_we = 1'b0;
    logic [8:0]  mem_wa = '0;
    logic [7:0]  mem_wd = '0;
    logic [1:0]  cmd_kind;
    logic [8:0]  cmd_addr;
    logic [15:0] cmd_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0]  bmem [512];
    logic        exp_bits [$];
    logic [26:0] exp_cmd [$];
    string       cur_tag = "R5";
    event        smp_ev;

    always #2.5 clk = ~clk;

    mw_eeprom_front uut (
        .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_di(mw_di),
        .org_wide(org_wide), .mw_do(mw_do), .mw_do_oe(mw_do_oe),
        .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd),
        .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    function automatic void check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    function automatic logic [15:0] word_of(bit org, int a);
        return org ? {bmem[2*a], bmem[2*a+1]} : {8'h00, bmem[a]};
    endfunction

    // scoreboard monitor for read data
    initial forever begin
        logic eb;
        @(smp_ev);
        if (exp_bits.size() == 0) begin
            check(1'b0, cur_tag, "unexpected read sample", mw_do, 0);
        end else begin
            eb = exp_bits.pop_front();
            check(mw_do_oe === 1'b1 && mw_do === eb, cur_tag, "read bit {oe,do}",
                  {mw_do_oe, mw_do}, {1'b1, eb});
        end
    end

    // scoreboard monitor for program commands
    initial forever begin
        logic [26:0] ec;
        @(negedge clk);
        if (rst_n && cmd_stb) begin
            if (exp_cmd.size() == 0) begin
                check(1'b0, cur_tag, "unexpected command {kind,addr,data}",
                      {cmd_kind, cmd_addr, cmd_data}, 0);
            end else begin
                ec = exp_cmd.pop_front();
                check({cmd_kind, cmd_addr, cmd_data} == ec, cur_tag,
                      "command {kind,addr,data}", {cmd_kind, cmd_addr, cmd_data}, ec);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_bit(bit b, bit smp);
        mw_di = b;
        idle(HALF);
        mw_clk = 1'b1;
        idle(HALF);
        if (smp) -> smp_ev;
        mw_clk = 1'b0;
    endtask

    task automatic cs_on();
        mw_cs = 1'b1;
        idle(4);
    endtask

    task automatic cs_off();
        mw_cs = 1'b0;
        mw_di = 1'b0;
        idle(12);
    endtask

    task automatic expect_cmd(int kind, int addr, int data);
        exp_cmd.push_back({2'(kind), 9'(addr), 16'(data)});
    endtask

    task automatic do_read(bit org, int addr, int words, int lead, string tag);
        int aw = org ? 8 : 9;
        int dw = org ? 16 : 8;
        int a = addr;
        cur_tag = tag;
        org_wide = org;
        idle(2);
        cs_on();
        for (int i = 0; i < lead; i++) sclk_bit(1'b0, 1'b0);
        check(mw_do_oe == 1'b0, "R1", "oe after leading zero clocks", mw_do_oe, 0);
        sclk_bit(1'b1, 1'b0);
        sclk_bit(1'b1, 1'b0);
        sclk_bit(1'b0, 1'b0);
        for (int i = aw - 1; i >= 0; i--) begin
            if (i == 0) exp_bits.push_back(1'b0);
            sclk_bit(addr[i], i == 0);
        end
        for (int w = 0; w < words; w++) begin
            logic [15:0] wv = word_of(org, a);
            for (int k = dw - 1; k >= 0; k--) begin
                exp_bits.push_back(wv[k]);
                sclk_bit(1'b0, 1'b1);
            end
            a = (a + 1) % (org ? 256 : 512);
        end
        cs_off();
        check(mw_do_oe == 1'b0, "R7", "oe after select low", mw_do_oe, 0);
        check(exp_bits.size() == 0, tag, "read bits left unchecked", exp_bits.size(), 0);
    endtask

    task automatic xfer(bit org, logic [1:0] op, int addr, int data, bit has_data,
                        int cut, int extra, string tag);
        logic [31:0] fb = 32'd1;
        int len = 1;
        int aw = org ? 8 : 9;
        int dw = org ? 16 : 8;
        cur_tag = tag;
        org_wide = org;
        idle(2);
        for (int i = 1; i >= 0; i--) begin fb = {fb[30:0], op[i]}; len++; end
        for (int i = aw - 1; i >= 0; i--) begin fb = {fb[30:0], addr[i]}; len++; end
        if (has_data)
            for (int i = dw - 1; i >= 0; i--) begin fb = {fb[30:0], data[i]}; len++; end
        cs_on();
        for (int i = 0; i < len && i < cut; i++) sclk_bit(fb[len-1-i], 1'b0);
        for (int i = 0; i < extra; i++) sclk_bit(1'b1, 1'b0);
        check(mw_do_oe == 1'b0, tag, "oe during non-read frame", mw_do_oe, 0);
        cs_off();
        check(exp_cmd.size() == 0, tag, "expected commands still pending", exp_cmd.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(5);
        check(mw_do_oe == 1'b0, "R7", "oe in reset", mw_do_oe, 0);
        rst_n = 1'b1;
        idle(5);
        check(mw_do_oe == 1'b0, "R7", "oe after reset", mw_do_oe, 0);
        check(cmd_stb == 1'b0, "R7", "strobe after reset", cmd_stb, 0);

        // R10: fill the array through the byte port
        for (int i = 0; i < 512; i++) begin
            logic [7:0] pv = 8'((i * 37 + 11) ^ (i >> 3));
            mem_we = 1'b1; mem_wa = 9'(i); mem_wd = pv; bmem[i] = pv;
            idle(1);
        end
        mem_we = 1'b0;
        idle(2);

        // R1/R5/R9: read while locked, after leading zero clocks
        do_read(1'b0, 5, 1, 3, "R1/R5/R9");
        // R6: narrow stream wraps 511 -> 0
        do_read(1'b0, 510, 3, 0, "R6");
        // R10/R6: wide stream, byte pairing and wrap 255 -> 0
        do_read(1'b1, 254, 3, 1, "R10/R6");

        // R4: write while locked issues nothing
        xfer(1'b0, 2'b01, 9, 8'hA5, 1'b1, FULL, 0, "R4");
        // R3: unlock (narrow, top bits 11)
        xfer(1'b0, 2'b00, 9'h180, 0, 1'b0, FULL, 0, "R3");
        // R3/R11: narrow write
        expect_cmd(0, 9'h1AB, 16'h005C);
        xfer(1'b0, 2'b01, 9'h1AB, 8'h5C, 1'b1, FULL, 0, "R3/R11");
        // R2: narrow write cut one bit short (20 clocks needed)
        xfer(1'b0, 2'b01, 9'h0AA, 8'h33, 1'b1, 19, 0, "R2");
        // R2/R11: wide write, 27 clocks
        expect_cmd(0, 9'h03C, 16'hBEEF);
        xfer(1'b1, 2'b01, 8'h3C, 16'hBEEF, 1'b1, FULL, 0, "R2/R11");
        // R8: wide erase followed by extra clocks with data in high
        expect_cmd(1, 9'h0FF, 0);
        xfer(1'b1, 2'b11, 8'hFF, 0, 1'b0, FULL, 5, "R8");
        // R3: narrow erase-all (top bits 10)
        expect_cmd(3, 0, 0);
        xfer(1'b0, 2'b00, 9'h100, 0, 1'b0, FULL, 0, "R3");
        // R3/R11: wide write-all (top bits 01)
        expect_cmd(2, 0, 16'h1234);
        xfer(1'b1, 2'b00, 8'h40, 16'h1234, 1'b1, FULL, 0, "R3/R11");
        // R2: wide erase cut at 10 of 11 clocks
        xfer(1'b1, 2'b11, 8'h10, 0, 1'b0, 10, 0, "R2");
        // R4: lock (wide, top bits 00) then erase is refused
        xfer(1'b1, 2'b00, 8'h00, 0, 1'b0, FULL, 0, "R4");
        xfer(1'b0, 2'b11, 9'h003, 0, 1'b0, FULL, 0, "R4");
        // R4: unlock in wide mode (top bits 11) then narrow erase goes out
        xfer(1'b1, 2'b00, 8'hC0, 0, 1'b0, FULL, 0, "R4");
        expect_cmd(1, 9'h003, 0);
        xfer(1'b0, 2'b11, 9'h003, 0, 1'b0, FULL, 0, "R4");
        // R9: read still works while unlocked
        do_read(1'b1, 17, 1, 0, "R9");

        idle(20);
        check(exp_cmd.size() == 0, "R11", "commands left unmatched", exp_cmd.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule